// File: doc/BRIEF.md
# SIMT Lane Mask Stack

This block keeps track of which lanes of a lockstep thread group are allowed to run while the group moves through structured control flow. The decoder passes in one control event per cycle. An event is one of if, else, endif, loop, break or endloop. With it come a per-lane predicate vector and a target PC. The block holds the live lane mask and a stack of divergence records. Each record holds the mask in force before the construct opened, the mask that is still owed the alternate path, the reconvergence PC, and a flag that marks it as a loop record.

The block outputs the current lane mask and a per-lane memory enable gated by that mask. It also outputs the reconvergence PC of the innermost open construct and a depth count. Three strobes tell the fetch side how to steer. One says the next path has no lanes and should be skipped. One says the innermost loop has run out of lanes. One says the loop should go round again. Overflow and underflow of the stack are latched as sticky error flags.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the lane mask is all ones, the depth is 0, `reconvPc` is 0 and both error flags are clear.
- R2: An if event (`evtKind`=1) pushes a record. From the next cycle the mask is the old mask AND `pred`, and `reconvPc` shows that event's `tgtPc`. In the event cycle itself, `branchSkip` is 1 exactly when that AND is zero.
- R3: An else event (`evtKind`=2) sets the mask to the lanes that were active at the matching if and had `pred` clear there. In the event cycle, `branchSkip` is 1 exactly when that set is empty.
- R4: An endif event (`evtKind`=3) pops the top record and restores the mask that was in force just before the matching if. Nested if constructs unwind in last-in, first-out order.
- R5: A loop event (`evtKind`=4) pushes a loop record holding the current mask and `tgtPc`. The mask itself is unchanged.
- R6: A break event (`evtKind`=5) removes the active lanes that have `pred` set from the mask. The same lanes are also removed from the saved and alternate masks of every record opened inside the innermost loop, so an endif inside the loop does not bring them back.
- R7: On an endloop event (`evtKind`=6), `pred` marks the lanes that continue. If any active lane continues, `loopBack` pulses and the mask becomes those lanes. If none continues, or a break leaves the loop record on top with no lanes, `loopExit` pulses, the loop record is popped and the mask saved at loop entry returns. Lanes that were inactive at loop entry therefore stay inactive.
- R8: `memEn` equals the lane mask while `memReq` is 1, and is all zeros while `memReq` is 0.
- R9: An if or loop event at depth `DEPTH` sets `ovfErr`, which stays set until reset. Mask and depth are left unchanged.
- R10: An else, endif, break or endloop event at depth 0 sets `udfErr`, which stays set until reset. The mask is left unchanged.
- R11: In a cycle with `evtValid` low, neither the mask nor the depth changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 1 | A control event is present this cycle |
| evtKind | input | 3 | 1 if, 2 else, 3 endif, 4 loop, 5 break, 6 endloop |
| pred | input | LANES | Per-lane predicate for the event |
| tgtPc | input | PCW | Reconvergence PC stored by if and loop |
| memReq | input | 1 | The group's current instruction accesses memory |
| activeMask | output | LANES | Current lane mask |
| memEn | output | LANES | Per-lane memory access enable |
| reconvPc | output | PCW | Reconvergence PC of the top record, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Number of open records |
| branchSkip | output | 1 | Path entered by this if or else has no lanes |
| loopExit | output | 1 | Innermost loop finishes with this event |
| loopBack | output | 1 | Endloop with lanes still iterating |
| ovfErr | output | 1 | Sticky stack overflow |
| udfErr | output | 1 | Sticky stack underflow |

## Verification
The if, else and endif path is driven first with a predicate that splits the lanes into halves and then with interleaved nibble patterns two levels deep. Halves show that the taken and alternate masks are complements inside the entry mask. The nested patterns show that each endif restores its own saved mask and not a neighbour's. An all-zero and an all-ones predicate isolate the skip strobe on the if and on the else. Break patterns are applied once with the loop record on top and once from inside an if within the loop, which separates a break that only narrows the live mask from one that also scrubs the nested records. A loop opened inside a half-mask if checks that loop exit restores the entry mask and not all lanes.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_IF      = 3'd1,
    EV_ELSE    = 3'd2,
    EV_ENDIF   = 3'd3,
    EV_LOOP    = 3'd4,
    EV_BREAK   = 3'd5,
    EV_ENDLOOP = 3'd6
  } evtKind_e;

  typedef enum logic [2:0] {
    M_KEEP,
    M_TAKEN,
    M_DEFER,
    M_SAVED,
    M_CLEAR
  } maskSel_e;

  typedef struct packed {
    logic     push;
    logic     pushLoop;
    logic     pop;
    logic     brk;
    maskSel_e sel;
    logic     setOvf;
    logic     setUdf;
  } strobe_t;

endpackage

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
  import simt_mask_pkg::*;
(
  input  logic       evtValid,
  input  logic [2:0] evtKind,
  input  logic       full,
  input  logic       empty,
  input  logic       topLoop,
  input  logic       takenEmpty,
  input  logic       clearEmpty,
  input  logic       deferEmpty,
  output strobe_t    st,
  output logic       branchSkip,
  output logic       loopExit,
  output logic       loopBack
);

  always_comb begin
    st         = '0;
    st.sel     = M_KEEP;
    branchSkip = 1'b0;
    loopExit   = 1'b0;
    loopBack   = 1'b0;
    if (evtValid) begin
      case (evtKind_e'(evtKind))
        EV_IF: begin
          if (full) st.setOvf = 1'b1;
          else begin
            st.push    = 1'b1;
            st.sel     = M_TAKEN;
            branchSkip = takenEmpty;
          end
        end
        EV_ELSE: begin
          if (empty) st.setUdf = 1'b1;
          else begin
            st.sel     = M_DEFER;
            branchSkip = deferEmpty;
          end
        end
        EV_ENDIF: begin
          if (empty) st.setUdf = 1'b1;
          else begin
            st.pop = 1'b1;
            st.sel = M_SAVED;
          end
        end
        EV_LOOP: begin
          if (full) st.setOvf = 1'b1;
          else begin
            st.push     = 1'b1;
            st.pushLoop = 1'b1;
          end
        end
        EV_BREAK: begin
          if (empty) st.setUdf = 1'b1;
          else if (topLoop && clearEmpty) begin
            st.pop   = 1'b1;
            st.sel   = M_SAVED;
            loopExit = 1'b1;
          end else begin
            st.brk = 1'b1;
            st.sel = M_CLEAR;
          end
        end
        EV_ENDLOOP: begin
          if (empty) st.setUdf = 1'b1;
          else if (takenEmpty) begin
            st.pop   = 1'b1;
            st.sel   = M_SAVED;
            loopExit = 1'b1;
          end else begin
            st.sel   = M_TAKEN;
            loopBack = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/simt_mask_data.sv
module simt_mask_data
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [LANES-1:0] pred,
  input  logic [PCW-1:0]   tgtPc,
  output logic [LANES-1:0] activeMask,
  output logic [PCW-1:0]   topReconv,
  output logic [SPW-1:0]   depth,
  output logic             full,
  output logic             empty,
  output logic             topLoop,
  output logic             takenEmpty,
  output logic             clearEmpty,
  output logic             deferEmpty,
  output logic             ovfErr,
  output logic             udfErr
);

  logic [LANES-1:0] savedQ  [DEPTH];
  logic [LANES-1:0] deferQ  [DEPTH];
  logic [PCW-1:0]   reconvQ [DEPTH];
  logic [DEPTH-1:0] loopQ;
  logic [LANES-1:0] activeQ, nextActive, taken, cleared, topSaved, topDefer;
  logic [SPW-1:0]   sp;
  logic [IW-1:0]    topIdx;
  logic [DEPTH-1:0] aboveLoop;
  logic             loopSeen;

  assign topIdx   = IW'(sp - SPW'(1));
  assign empty    = (sp == '0);
  assign full     = (sp == SPW'(DEPTH));
  assign taken    = activeQ & pred;
  assign cleared  = activeQ & ~pred;
  assign topSaved = empty ? '1 : savedQ[topIdx];
  assign topDefer = empty ? '0 : deferQ[topIdx];
  assign topLoop  = !empty && loopQ[topIdx];
  assign topReconv = empty ? '0 : reconvQ[topIdx];
  assign takenEmpty = (taken == '0);
  assign clearEmpty = (cleared == '0);
  assign deferEmpty = (topDefer == '0);
  assign activeMask = activeQ;
  assign depth      = sp;

  // Records opened after the innermost loop record: a break scrubs these.
  always_comb begin
    aboveLoop = '0;
    loopSeen  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (i < int'(sp) && !loopSeen) begin
        if (loopQ[i]) loopSeen = 1'b1;
        else          aboveLoop[i] = 1'b1;
      end
    end
    if (!loopSeen) aboveLoop = '0;
  end

  always_comb begin
    case (st.sel)
      M_TAKEN: nextActive = taken;
      M_DEFER: nextActive = topDefer;
      M_SAVED: nextActive = topSaved;
      M_CLEAR: nextActive = cleared;
      default: nextActive = activeQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= '1;
      sp      <= '0;
      ovfErr  <= 1'b0;
      udfErr  <= 1'b0;
    end else begin
      activeQ <= nextActive;
      if (st.push)     sp <= sp + SPW'(1);
      else if (st.pop) sp <= sp - SPW'(1);
      if (st.setOvf) ovfErr <= 1'b1;
      if (st.setUdf) udfErr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopQ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        savedQ[i]  <= '1;
        deferQ[i]  <= '0;
        reconvQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (st.push && sp == SPW'(i)) begin
          savedQ[i]  <= activeQ;
          deferQ[i]  <= st.pushLoop ? '0 : cleared;
          reconvQ[i] <= tgtPc;
          loopQ[i]   <= st.pushLoop;
        end else if (st.brk && aboveLoop[i]) begin
          savedQ[i] <= savedQ[i] & ~taken;
          deferQ[i] <= deferQ[i] & ~taken;
        end
      end
    end
  end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PCW   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       evtValid,
  input  logic [2:0]                 evtKind,
  input  logic [LANES-1:0]           pred,
  input  logic [PCW-1:0]             tgtPc,
  input  logic                       memReq,
  output logic [LANES-1:0]           activeMask,
  output logic [LANES-1:0]           memEn,
  output logic [PCW-1:0]             reconvPc,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       branchSkip,
  output logic                       loopExit,
  output logic                       loopBack,
  output logic                       ovfErr,
  output logic                       udfErr
);

  strobe_t st;
  logic full, empty, topLoop, takenEmpty, clearEmpty, deferEmpty;

  simt_mask_ctrl uCtrl (
    .evtValid  (evtValid),
    .evtKind   (evtKind),
    .full      (full),
    .empty     (empty),
    .topLoop   (topLoop),
    .takenEmpty(takenEmpty),
    .clearEmpty(clearEmpty),
    .deferEmpty(deferEmpty),
    .st        (st),
    .branchSkip(branchSkip),
    .loopExit  (loopExit),
    .loopBack  (loopBack)
  );

  simt_mask_data #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .pred      (pred),
    .tgtPc     (tgtPc),
    .activeMask(activeMask),
    .topReconv (reconvPc),
    .depth     (depth),
    .full      (full),
    .empty     (empty),
    .topLoop   (topLoop),
    .takenEmpty(takenEmpty),
    .clearEmpty(clearEmpty),
    .deferEmpty(deferEmpty),
    .ovfErr    (ovfErr),
    .udfErr    (udfErr)
  );

  assign memEn = memReq ? activeMask : '0;

endmodule

// File: rtl/simt_mask_checker.sv
module simt_mask_checker
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       evtValid,
  input logic [2:0]                 evtKind,
  input logic [LANES-1:0]           pred,
  input logic                       memReq,
  input logic [LANES-1:0]           activeMask,
  input logic [LANES-1:0]           memEn,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic                       ovfErr,
  input logic                       udfErr
);

  AST_IF_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == EV_IF && depth != DEPTH) |=> activeMask == ($past(activeMask) & $past(pred))); // R2

  AST_ENDIF_POP: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == EV_ENDIF && depth != 0) |=> depth == $past(depth) - 1'b1); // R4

  AST_LOOP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == EV_LOOP && depth != DEPTH) |=> $stable(activeMask)); // R5

  AST_MEM_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (memEn & ~activeMask) == '0 && (memReq || memEn == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr && depth <= DEPTH); // R9

  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    udfErr |=> udfErr); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |=> $stable(activeMask) && $stable(depth)); // R11

endmodule

bind simt_mask_stack simt_mask_checker #(.LANES(LANES), .DEPTH(DEPTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .evtValid  (evtValid),
  .evtKind   (evtKind),
  .pred      (pred),
  .memReq    (memReq),
  .activeMask(activeMask),
  .memEn     (memEn),
  .depth     (depth),
  .ovfErr    (ovfErr),
  .udfErr    (udfErr)
);

// File: tb/tb_simt_mask_stack.sv
module tb_simt_mask_stack;

  localparam int LANES = 32;
  localparam int DEPTH = 8;
  localparam int PCW   = 16;

  localparam logic [2:0] K_IF = 3'd1, K_ELSE = 3'd2, K_ENDIF = 3'd3,
                         K_LOOP = 3'd4, K_BREAK = 3'd5, K_ENDLOOP = 3'd6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [2:0] evtKind = '0;
  logic [LANES-1:0] pred = '0;
  logic [PCW-1:0] tgtPc = '0;
  logic memReq = 1'b0;
  logic [LANES-1:0] activeMask, memEn;
  logic [PCW-1:0] reconvPc;
  logic [$clog2(DEPTH+1)-1:0] depth;
  logic branchSkip, loopExit, loopBack, ovfErr, udfErr;
  logic sSkip, sExit, sBack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .pred(pred), .tgtPc(tgtPc), .memReq(memReq), .activeMask(activeMask),
    .memEn(memEn), .reconvPc(reconvPc), .depth(depth), .branchSkip(branchSkip),
    .loopExit(loopExit), .loopBack(loopBack), .ovfErr(ovfErr), .udfErr(udfErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [2:0] k, input logic [LANES-1:0] p, input logic [PCW-1:0] t);
    evtValid = 1'b1; evtKind = k; pred = p; tgtPc = t;
    #1;
    sSkip = branchSkip; sExit = loopExit; sBack = loopBack;
    @(posedge clk); #1;
    evtValid = 1'b0; evtKind = '0; pred = '0; tgtPc = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 mask", activeMask, 64'hFFFFFFFF);
    chk("R1 depth", depth, 0);
    chk("R1 reconvPc", reconvPc, 0);
    chk("R1 flags", {ovfErr, udfErr}, 0);
  endtask

  task automatic tIfElse();
    ev(K_IF, 32'h0000FFFF, 16'h0040);
    chk("R2 skip", sSkip, 0);
    chk("R2 mask", activeMask, 64'h0000FFFF);
    chk("R2 reconvPc", reconvPc, 16'h0040);
    ev(K_ELSE, '0, '0);
    chk("R3 mask", activeMask, 64'hFFFF0000);
    chk("R3 skip", sSkip, 0);
    ev(K_ENDIF, '0, '0);
    chk("R4 mask", activeMask, 64'hFFFFFFFF);
    chk("R4 depth", depth, 0);
  endtask

  task automatic tNested();
    ev(K_IF, 32'h0F0F0F0F, 16'h0100);
    ev(K_IF, 32'h000000FF, 16'h0080);
    chk("R2 nested mask", activeMask, 64'h0000000F);
    chk("R2 nested reconvPc", reconvPc, 16'h0080);
    ev(K_ELSE, '0, '0);
    chk("R3 nested mask", activeMask, 64'h0F0F0F00);
    ev(K_ENDIF, '0, '0);
    chk("R4 inner restore", activeMask, 64'h0F0F0F0F);
    chk("R4 inner reconvPc", reconvPc, 16'h0100);
    ev(K_ELSE, '0, '0);
    chk("R3 outer else", activeMask, 64'hF0F0F0F0);
    ev(K_ENDIF, '0, '0);
    chk("R4 outer restore", activeMask, 64'hFFFFFFFF);
  endtask

  task automatic tSkip();
    ev(K_IF, 32'h0, 16'h0010);
    chk("R2 empty taken skip", sSkip, 1);
    chk("R2 empty taken mask", activeMask, 0);
    ev(K_ELSE, '0, '0);
    chk("R3 else no skip", sSkip, 0);
    chk("R3 else all lanes", activeMask, 64'hFFFFFFFF);
    ev(K_ENDIF, '0, '0);
    ev(K_IF, 32'hFFFFFFFF, 16'h0010);
    chk("R2 full taken skip", sSkip, 0);
    ev(K_ELSE, '0, '0);
    chk("R3 empty else skip", sSkip, 1);
    chk("R3 empty else mask", activeMask, 0);
    ev(K_ENDIF, '0, '0);
    chk("R4 after skip", activeMask, 64'hFFFFFFFF);
  endtask

  task automatic tLoop();
    ev(K_LOOP, '0, 16'h0200);
    chk("R5 mask", activeMask, 64'hFFFFFFFF);
    chk("R5 depth", depth, 1);
    chk("R5 reconvPc", reconvPc, 16'h0200);
    ev(K_BREAK, 32'h000000FF, '0);
    chk("R6 break mask", activeMask, 64'hFFFFFF00);
    chk("R7 no exit on partial break", sExit, 0);
    ev(K_ENDLOOP, 32'hFFFFFFFF, '0);
    chk("R7 loopBack", sBack, 1);
    chk("R7 mask after back", activeMask, 64'hFFFFFF00);
    ev(K_ENDLOOP, 32'h00FF0000, '0);
    chk("R7 continuing lanes", activeMask, 64'h00FF0000);
    ev(K_BREAK, 32'h00FF0000, '0);
    chk("R7 exit on last break", sExit, 1);
    chk("R7 restored mask", activeMask, 64'hFFFFFFFF);
    chk("R7 depth", depth, 0);
    ev(K_IF, 32'h0000FFFF, 16'h0300);
    ev(K_LOOP, '0, 16'h0280);
    ev(K_ENDLOOP, 32'h0, '0);
    chk("R7 endloop exit", sExit, 1);
    chk("R7 entry mask kept", activeMask, 64'h0000FFFF);
    chk("R7 entry depth", depth, 1);
    ev(K_ENDIF, '0, '0);
  endtask

  task automatic tBreakInIf();
    ev(K_LOOP, '0, 16'h0400);
    ev(K_IF, 32'h000000FF, 16'h0380);
    ev(K_BREAK, 32'h0000000F, '0);
    chk("R6 nested break mask", activeMask, 64'h000000F0);
    chk("R6 nested break no exit", sExit, 0);
    ev(K_ELSE, '0, '0);
    chk("R6 else path", activeMask, 64'hFFFFFF00);
    ev(K_ENDIF, '0, '0);
    chk("R6 scrubbed restore", activeMask, 64'hFFFFFFF0);
    ev(K_ENDLOOP, 32'h0, '0);
    chk("R7 exit after nested", sExit, 1);
    chk("R7 mask after nested", activeMask, 64'hFFFFFFFF);
  endtask

  task automatic tMem();
    ev(K_IF, 32'h12345678, 16'h0020);
    memReq = 1'b1; #1;
    chk("R8 memEn on", memEn, 64'h12345678);
    memReq = 1'b0; #1;
    chk("R8 memEn off", memEn, 0);
    @(posedge clk); #1;
    ev(K_ENDIF, '0, '0);
  endtask

  task automatic tIdle();
    ev(K_IF, 32'hA5A5A5A5, 16'h0030);
    evtKind = K_ENDIF; pred = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 idle mask", activeMask, 64'hA5A5A5A5);
    chk("R11 idle depth", depth, 1);
    evtKind = '0; pred = '0;
    ev(K_ENDIF, '0, '0);
  endtask

  task automatic tOverflow();
    doReset();
    for (int i = 0; i < DEPTH; i++) ev(K_LOOP, '0, 16'(i));
    chk("R9 full no flag", ovfErr, 0);
    ev(K_IF, 32'h0000FFFF, 16'h0999);
    chk("R9 flag", ovfErr, 1);
    chk("R9 depth kept", depth, DEPTH);
    chk("R9 mask kept", activeMask, 64'hFFFFFFFF);
    for (int i = 0; i < DEPTH; i++) ev(K_ENDLOOP, '0, '0);
    chk("R9 sticky", ovfErr, 1);
    chk("R9 unwound", depth, 0);
  endtask

  task automatic tUnderflow();
    doReset();
    ev(K_ENDIF, '0, '0);
    chk("R10 flag", udfErr, 1);
    chk("R10 mask kept", activeMask, 64'hFFFFFFFF);
    chk("R10 depth kept", depth, 0);
    ev(K_BREAK, 32'hFFFFFFFF, '0);
    chk("R10 break mask kept", activeMask, 64'hFFFFFFFF);
    @(posedge clk); #1;
    chk("R10 sticky", udfErr, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    tIfElse();
    tNested();
    tSkip();
    tLoop();
    tBreakInIf();
    tMem();
    tIdle();
    tOverflow();
    tUnderflow();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule